// File: doc/BRIEF.md
# Prioritized Interrupt Pending Arbiter

This block collects requests from 109 peripheral interrupt lines and one nonmaskable input. It holds them as pending and picks, on every cycle, the single request the core should service next. Each line has its own capture mode: level lines mirror their input, and pulse lines latch a rising edge. Each line also has an enable and a 3-bit priority in which a lower number means more urgent. A global split setting divides the priority into a group part and a subpriority part. The block raises a preemption flag when the chosen request's group beats the most urgent group among the interrupts already being serviced.

Software-side configuration arrives through a single write port that carries an operation code, a line index and a small data field. The core uses a one-cycle acknowledge to take the currently selected request, which moves it from pending to active. It reports the end of a handler with a completion strobe carrying the interrupt number.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset no request is selected, preempt is low, every line is disabled, in level mode, at priority 0, and the split setting is 0.
- R2: A line in pulse mode (cfg_op 2, cfg_data[0]=1) becomes pending on a 0-to-1 change of its input seen at a clock edge. It stays pending after the input falls, until it is acknowledged or cleared with cfg_op 4. cfg_op 3 sets it pending.
- R3: A level-mode line is pending exactly while its input is high and it is not active. Set and clear operations (cfg_op 3 and 4) have no effect on a level-mode line.
- R4: Only lines that are both pending and enabled (cfg_op 0, cfg_data[0]) take part in selection. A disabled line keeps its pending state and is selected once enabled.
- R5: The selected line has the numerically lowest priority among candidates. A tie goes to the lowest line number, lines 0 to 108 included.
- R6: A priority write (cfg_op 1, cfg_data[2:0]) changes the selection from the next cycle on.
- R7: With split value s (cfg_op 5, cfg_data[1:0]), the group of a priority p is p shifted right by s. preempt is high when a request is selected and either no line is active or its group is strictly below the lowest group among active lines. An equal group gives no preemption.
- R8: The nonmaskable input latches on a rising edge, is selected as number 109 ahead of every line regardless of any enable, and preempts unless it is itself active. While it is active no line preempts.
- R9: ack while a request is selected clears that request's pending bit and makes it active. done with done_id clears that number's active state.
- R10: A rising edge on a pulse line that is active, including in the very cycle it is acknowledged, makes the line pending again.
- R11: A level line whose input is still high when its completion arrives is pending again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 109 | Peripheral interrupt lines |
| nmi_in | input | 1 | Nonmaskable interrupt input |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Operation: 0 enable, 1 priority, 2 mode, 3 set pending, 4 clear pending, 5 split |
| cfg_idx | input | 7 | Line number addressed by the write |
| cfg_data | input | 3 | Write data |
| ack | input | 1 | Core takes the selected request |
| done | input | 1 | Handler completion strobe |
| done_id | input | 7 | Number whose handler completed |
| sel_valid | output | 1 | A request is selected |
| sel_id | output | 7 | Selected number (109 = nonmaskable) |
| sel_prio | output | 3 | Priority of the selected request |
| preempt | output | 1 | Selected request may preempt the active one |

## Verification
The acknowledge of a pulse line and a new rising edge on that same line can occur in the same cycle. The bench provokes this by raising the line in exactly the cycle it drives ack. It judges the outcome at the ports: the line must stay selected with preempt low, because it is active at its own group. After its completion, preempt must rise. A second overlap is a level line still asserted when its done arrives, which must reappear as selected one cycle later.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int PRIO_W  = 3;
    localparam int SPLIT_W = 2;

    typedef enum logic [2:0] {
        OP_ENABLE  = 3'd0,
        OP_PRIO    = 3'd1,
        OP_MODE    = 3'd2,
        OP_SETPEND = 3'd3,
        OP_CLRPEND = 3'd4,
        OP_SPLIT   = 3'd5
    } cfg_op_e;

    typedef struct packed {
        logic              en;
        logic              pulse;
        logic [PRIO_W-1:0] prio;
        logic              pend;
        logic              act;
        logic              prev;
    } line_st_t;

    typedef struct packed {
        logic [SPLIT_W-1:0] split;
        logic               nmi_prev;
        logic               nmi_pend;
        logic               nmi_act;
    } top_st_t;
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              cfg_hit,
    input  cfg_op_e           cfg_op,
    input  logic [PRIO_W-1:0] cfg_data,
    input  logic              ack_hit,
    input  logic              done_hit,
    output logic              en_o,
    output logic              pend_o,
    output logic              act_o,
    output logic [PRIO_W-1:0] prio_o
);
    line_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        if (cfg_hit) begin
            case (cfg_op)
                OP_ENABLE: st_d.en    = cfg_data[0];
                OP_PRIO:   st_d.prio  = cfg_data;
                OP_MODE:   st_d.pulse = cfg_data[0];
                default:   ;
            endcase
        end
        st_d.act = (st_q.act | ack_hit) & ~done_hit;
        if (st_q.pulse) begin
            if ((cfg_hit && cfg_op == OP_CLRPEND) || ack_hit)
                st_d.pend = 1'b0;
            if ((irq_in && !st_q.prev) || (cfg_hit && cfg_op == OP_SETPEND))
                st_d.pend = 1'b1;
        end else begin
            st_d.pend = irq_in & ~st_d.act;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;
    assign prio_o = st_q.prio;

    // R2
    pulse_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse && irq_in && !st_q.prev |=> pend_o);

    // R3
    level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pulse && !irq_in |=> !pend_o);

    // R9
    ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit && !done_hit |=> act_o);

    // R11
    level_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pulse && act_o && done_hit && !ack_hit && irq_in |=> pend_o);
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 109,
    parameter int IDX_W   = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_IRQ-1:0]             pend,
    input  logic [NUM_IRQ-1:0]             en,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    input  logic                           nmi_pend,
    output logic                           valid_o,
    output logic [IDX_W-1:0]               id_o,
    output logic [PRIO_W-1:0]              prio_o
);
    localparam logic [IDX_W-1:0] NMI_ID = IDX_W'(NUM_IRQ);

    logic              found;
    logic [IDX_W-1:0]  best_id;
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '1;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend[i] && en[i] && (!found || prio[i] <= best_prio)) begin
                found     = 1'b1;
                best_id   = IDX_W'(i);
                best_prio = prio[i];
            end
        end
        if (nmi_pend) begin
            found     = 1'b1;
            best_id   = NMI_ID;
            best_prio = '0;
        end
    end

    assign valid_o = found;
    assign id_o    = best_id;
    assign prio_o  = best_prio;

    // R4
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && id_o != NMI_ID |-> pend[id_o] && en[id_o]);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 109,
    localparam int IDX_W  = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               nmi_in,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_op,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_data,
    input  logic               ack,
    input  logic               done,
    input  logic [IDX_W-1:0]   done_id,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_id,
    output logic [PRIO_W-1:0]  sel_prio,
    output logic               preempt
);
    localparam logic [IDX_W-1:0] NMI_ID = IDX_W'(NUM_IRQ);

    cfg_op_e                        op;
    logic [NUM_IRQ-1:0]             en_vec, pend_vec, act_vec;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_vec;
    top_st_t                        st_d, st_q;
    logic                           act_any;
    logic [PRIO_W-1:0]              act_min;
    logic                           take;

    assign op   = cfg_op_e'(cfg_op);
    assign take = ack && sel_valid;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        irq_line_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[i]),
            .cfg_hit  (cfg_wr && cfg_idx == IDX_W'(i)),
            .cfg_op   (op),
            .cfg_data (cfg_data),
            .ack_hit  (take && sel_id == IDX_W'(i)),
            .done_hit (done && done_id == IDX_W'(i)),
            .en_o     (en_vec[i]),
            .pend_o   (pend_vec[i]),
            .act_o    (act_vec[i]),
            .prio_o   (prio_vec[i])
        );
    end

    irq_select #(
        .NUM_IRQ (NUM_IRQ),
        .IDX_W   (IDX_W)
    ) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_vec),
        .en       (en_vec),
        .prio     (prio_vec),
        .nmi_pend (st_q.nmi_pend),
        .valid_o  (sel_valid),
        .id_o     (sel_id),
        .prio_o   (sel_prio)
    );

    always_comb begin
        st_d          = st_q;
        st_d.nmi_prev = nmi_in;
        if (cfg_wr && op == OP_SPLIT)
            st_d.split = cfg_data[SPLIT_W-1:0];
        if (take && sel_id == NMI_ID)
            st_d.nmi_pend = 1'b0;
        if (nmi_in && !st_q.nmi_prev)
            st_d.nmi_pend = 1'b1;
        st_d.nmi_act = (st_q.nmi_act | (take && sel_id == NMI_ID))
                       & ~(done && done_id == NMI_ID);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        act_any = 1'b0;
        act_min = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (act_vec[i] && (!act_any || (prio_vec[i] >> st_q.split) < act_min)) begin
                act_any = 1'b1;
                act_min = prio_vec[i] >> st_q.split;
            end
        end
    end

    always_comb begin
        if (!sel_valid)
            preempt = 1'b0;
        else if (sel_id == NMI_ID)
            preempt = !st_q.nmi_act;
        else if (st_q.nmi_act)
            preempt = 1'b0;
        else
            preempt = !act_any || ((sel_prio >> st_q.split) < act_min);
    end

    // R8
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nmi_pend && !st_q.nmi_act |-> sel_valid && sel_id == NMI_ID && preempt);

    // R8
    nmi_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nmi_act && sel_id != NMI_ID |-> !preempt);

    // R7
    preempt_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> sel_valid);
endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
    localparam int N = 109;
    localparam logic [2:0] C_EN = 3'd0, C_PRIO = 3'd1, C_MODE = 3'd2,
                           C_SET = 3'd3, C_CLR = 3'd4, C_SPLIT = 3'd5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         nmi_in = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [2:0]   cfg_op = '0;
    logic [6:0]   cfg_idx = '0;
    logic [2:0]   cfg_data = '0;
    logic         ack = 1'b0;
    logic         done = 1'b0;
    logic [6:0]   done_id = '0;
    logic         sel_valid;
    logic [6:0]   sel_id;
    logic [2:0]   sel_prio;
    logic         preempt;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .cfg_wr(cfg_wr), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .ack(ack), .done(done), .done_id(done_id),
        .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio), .preempt(preempt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_sel(input string tag, input bit v, input int id, input bit pre);
        chk({tag, " valid"}, int'(sel_valid), int'(v));
        if (v) chk({tag, " id"}, int'(sel_id), id);
        chk({tag, " preempt"}, int'(preempt), int'(pre));
    endtask

    task automatic wr(input logic [2:0] op, input int idx, input int data);
        cfg_wr = 1'b1; cfg_op = op; cfg_idx = 7'(idx); cfg_data = 3'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic line_cfg(input int idx, input bit pulse, input int prio);
        wr(C_MODE, idx, int'(pulse));
        wr(C_PRIO, idx, prio);
        wr(C_EN, idx, 1);
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_done(input int id);
        done = 1'b1; done_id = 7'(id); @(negedge clk); done = 1'b0;
    endtask

    task automatic t_reset();
        chk_sel("R1 reset", 0, 0, 0);
        irq_in[3] = 1'b1; @(negedge clk);
        chk_sel("R1 disabled line", 0, 0, 0);
        irq_in[3] = 1'b0; @(negedge clk);
    endtask

    task automatic t_pulse();
        line_cfg(5, 1, 3);
        irq_in[5] = 1'b1; @(negedge clk); irq_in[5] = 1'b0;
        chk_sel("R2 latched", 1, 5, 1);
        @(negedge clk); @(negedge clk);
        chk_sel("R2 held", 1, 5, 1);
        wr(C_CLR, 5, 0);
        chk_sel("R2 cleared", 0, 0, 0);
    endtask

    task automatic t_level();
        line_cfg(7, 0, 2);
        irq_in[7] = 1'b1; @(negedge clk);
        chk_sel("R3 level high", 1, 7, 1);
        irq_in[7] = 1'b0; @(negedge clk);
        chk_sel("R3 level low", 0, 0, 0);
        wr(C_SET, 7, 0);
        chk_sel("R3 set ignored", 0, 0, 0);
    endtask

    task automatic t_enable();
        wr(C_MODE, 9, 1); wr(C_PRIO, 9, 6);
        irq_in[9] = 1'b1; @(negedge clk); irq_in[9] = 1'b0;
        chk_sel("R4 disabled", 0, 0, 0);
        wr(C_EN, 9, 1);
        chk_sel("R4 enabled later", 1, 9, 1);
        wr(C_CLR, 9, 0);
    endtask

    task automatic t_order();
        line_cfg(20, 1, 4); line_cfg(30, 1, 2); line_cfg(40, 1, 2);
        wr(C_SET, 20, 0); wr(C_SET, 30, 0); wr(C_SET, 40, 0);
        chk_sel("R5 lowest prio, tie low index", 1, 30, 1);
        wr(C_CLR, 30, 0);
        chk_sel("R5 next", 1, 40, 1);
        wr(C_PRIO, 20, 1);
        chk_sel("R6 reprioritized", 1, 20, 1);
        wr(C_CLR, 20, 0); wr(C_CLR, 40, 0);
        line_cfg(0, 1, 0); line_cfg(108, 1, 0);
        wr(C_SET, 108, 0); wr(C_SET, 0, 0);
        chk_sel("R5 edge lines tie", 1, 0, 1);
        wr(C_CLR, 0, 0);
        chk_sel("R5 last line", 1, 108, 1);
        wr(C_CLR, 108, 0);
    endtask

    task automatic t_preempt();
        line_cfg(50, 1, 5); wr(C_SET, 50, 0);
        chk_sel("R7 nothing active", 1, 50, 1);
        do_ack();
        chk_sel("R9 acked", 0, 0, 0);
        line_cfg(60, 1, 5); wr(C_SET, 60, 0);
        chk_sel("R7 equal group", 1, 60, 0);
        line_cfg(61, 1, 4); wr(C_SET, 61, 0);
        chk_sel("R7 better group", 1, 61, 1);
        wr(C_SPLIT, 0, 1);
        chk_sel("R7 split 1", 1, 61, 0);
        wr(C_SPLIT, 0, 3);
        chk_sel("R7 split 3", 1, 61, 0);
        wr(C_SPLIT, 0, 1);
        do_done(50);
        chk_sel("R9 done clears active", 1, 61, 1);
        wr(C_SPLIT, 0, 0);
        wr(C_CLR, 60, 0); wr(C_CLR, 61, 0);
    endtask

    task automatic t_nmi();
        line_cfg(70, 1, 0); wr(C_SET, 70, 0);
        chk_sel("R8 before", 1, 70, 1);
        nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
        chk_sel("R8 nmi wins", 1, 109, 1);
        do_ack();
        chk_sel("R8 nmi active blocks", 1, 70, 0);
        do_done(109);
        chk_sel("R9 nmi done", 1, 70, 1);
        wr(C_CLR, 70, 0);
    endtask

    task automatic t_collision();
        line_cfg(80, 1, 1); wr(C_SET, 80, 0);
        chk_sel("R10 before", 1, 80, 1);
        ack = 1'b1; irq_in[80] = 1'b1;
        @(negedge clk);
        ack = 1'b0; irq_in[80] = 1'b0;
        chk_sel("R10 repend on ack", 1, 80, 0);
        do_done(80);
        chk_sel("R10 after done", 1, 80, 1);
        wr(C_CLR, 80, 0);
    endtask

    task automatic t_level_repend();
        line_cfg(90, 0, 3);
        irq_in[90] = 1'b1; @(negedge clk);
        chk_sel("R11 asserted", 1, 90, 1);
        do_ack();
        chk_sel("R11 while active", 0, 0, 0);
        do_done(90);
        chk_sel("R11 repend", 1, 90, 1);
        irq_in[90] = 1'b0; @(negedge clk);
        chk_sel("R11 released", 0, 0, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulse();
        t_level();
        t_enable();
        t_order();
        t_preempt();
        t_nmi();
        t_collision();
        t_level_repend();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule